// File: doc/BRIEF.md
# Event Record Queue with Read-Pop Window

This block gathers 8-bit event records from three producers (keypad, general-purpose input and logic) and keeps them for a host processor in a 16-deep first-in first-out store. Each producer feeds a one-entry holding register. A fixed-priority arbiter moves at most one held record per cycle into the store. While the host bus is busy with the queue window, the arbiter is held off, and held records drain after the bus goes idle.

The host reads through a register window. A read strobe to any address of the window returns the oldest record and removes it, so records can only come out in arrival order. The block publishes the number of stored records. When a record has to be thrown away, it sets a sticky overflow flag. It also drives an interrupt that follows the flag when the interrupt enable is set.

Top module: `evq_top`

## Requirements
- R1: Records leave in the order they were written, and each 8-bit record is returned unchanged (bit 7 = event state, bits 6:0 = event identifier).
- R2: After reset, `ev_count` is 0, `rd_data` is 0x00 and `irq` is 0. `ev_count` always equals the number of stored records (0 to 16) and changes in the cycle after the edge that writes or removes a record.
- R3: A clock edge with `rd_stb` high and `rd_addr` in 0x03..0x12 puts the oldest record on `rd_data` after that edge, removes it and lowers the count by one. With `rd_stb` high and an address outside the window, `rd_data` becomes 0x00 and nothing is removed. `rd_data` is 0x00 after every edge without a window read.
- R4: A window read of an empty queue gives `rd_data` 0x00 and the count stays 0.
- R5: A window read and a record write on the same edge leave the count unchanged. The new record goes behind the surviving records, and this works even when the store is full.
- R6: A producer event that is sampled on an edge goes into its holding register. It is written to the store on the next edge at which `bus_busy` is low and it wins arbitration. No record enters the store on an edge where `bus_busy` is high.
- R7: When several holding registers are occupied, one record per edge is written, in the order keypad, then GPI, then logic.
- R8: Keypad events are always captured. GPI and logic events are captured only while `gpi_rec_en` or `lgc_rec_en` respectively is high. Otherwise they are ignored and the count does not change.
- R9: A record written to a full store (16 records, no read on the same edge) is discarded and the stored records are unchanged. An event that arrives at an occupied holding register that is not draining on the same edge is discarded. Both cases set `ovf_flag`.
- R10: `ovf_flag` stays set until an edge with `ovf_clr` high. If set and clear occur on the same edge, set wins.
- R11: `irq` is high exactly when `ovf_flag` and `ovf_irq_en` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_vld | input | 1 | Keypad event present |
| key_rec | input | 8 | Keypad event record |
| gpi_vld | input | 1 | GPI event present |
| gpi_rec | input | 8 | GPI event record |
| gpi_rec_en | input | 1 | Capture GPI events |
| lgc_vld | input | 1 | Logic event present |
| lgc_rec | input | 8 | Logic event record |
| lgc_rec_en | input | 1 | Capture logic events |
| bus_busy | input | 1 | Host transaction on the queue window; blocks writes |
| rd_stb | input | 1 | Host read strobe |
| rd_addr | input | 8 | Host read address |
| rd_data | output | 8 | Registered read result |
| ev_count | output | 5 | Stored record count |
| ovf_clr | input | 1 | Clear overflow flag |
| ovf_irq_en | input | 1 | Overflow interrupt enable |
| ovf_flag | output | 1 | Sticky overflow status |
| irq | output | 1 | Overflow interrupt |

## Verification
The assertions assume that `rst_n` is released only once and that the producers' valid and record inputs are stable across each sampling edge. They also assume that `bus_busy` is the only thing that stalls the arbiter. The bench changes every input at the falling edge, so each rising edge sees settled values. Its random phase picks read addresses on both sides of the window and toggles `bus_busy` and the capture enables freely. This exercises paused draining, simultaneous reads and writes, and holding-register collisions without breaking those assumptions.

// File: rtl/evq_pkg.sv
package evq_pkg;
   localparam int SRC_N = 3;
   typedef enum int {
      SRC_KEY = 0,
      SRC_GPI = 1,
      SRC_LGC = 2
   } src_e;
endpackage

// File: rtl/evq_hold.sv
module evq_hold #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap,
   input  logic [W-1:0] din,
   input  logic         take,
   output logic         full,
   output logic [W-1:0] dout,
   output logic         drop
);
   generate
      if (W < 2) begin : g_bad_w
         $error("evq_hold: W must be at least 2");
      end
   endgenerate

   assign drop = cap & full & ~take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         dout <= '0;
      end else if (cap && (!full || take)) begin
         full <= 1'b1;
         dout <= din;
      end else if (take) begin
         full <= 1'b0;
      end
   end

   AST_TAKE_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> full); // R7
endmodule

// File: rtl/evq_arb.sv
module evq_arb #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic         busy,
   output logic [N-1:0] grant
);
   generate
      if (N < 2) begin : g_bad_n
         $error("evq_arb: N must be at least 2");
      end
   endgenerate

   always_comb begin
      logic taken;
      taken = 1'b0;
      grant = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !taken && !busy) begin
            grant[i] = 1'b1;
            taken    = 1'b1;
         end
      end
   end

   AST_ARB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R7

   generate
      for (genvar i = 1; i < N; i++) begin : g_prio
         AST_ARB_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |-> !(|req[i-1:0])); // R7
      end
   endgenerate
endmodule

// File: rtl/evq_queue.sv
module evq_queue #(
   parameter int DEPTH = 16,
   parameter int W     = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [W-1:0]     wdata,
   input  logic             pop,
   output logic [CNT_W-1:0] cnt,
   output logic [W-1:0]     head,
   output logic             ovf
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("evq_queue: DEPTH must be at least 2");
      end
   endgenerate

   logic             pop_eff;
   logic             full;
   logic             accept;
   logic [CNT_W-1:0] wr_idx;
   logic [W-1:0]     mem [DEPTH];
   logic [W-1:0]     nxt [DEPTH];

   assign full    = (cnt == CNT_W'(DEPTH));
   assign pop_eff = pop && (cnt != '0);
   assign accept  = push && (!full || pop_eff);
   assign ovf     = push && full && !pop_eff;
   assign wr_idx  = cnt - CNT_W'(pop_eff);
   assign head    = mem[0];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         logic [W-1:0] shifted;
         if (i == DEPTH - 1) begin : g_last
            assign shifted = pop_eff ? '0 : mem[i];
         end else begin : g_mid
            assign shifted = pop_eff ? mem[i+1] : mem[i];
         end
         assign nxt[i] = (accept && wr_idx == CNT_W'(i)) ? wdata : shifted;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         cnt <= cnt + CNT_W'(accept) - CNT_W'(pop_eff);
         for (int i = 0; i < DEPTH; i++) mem[i] <= nxt[i];
      end
   end

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH)); // R2
   AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_eff && !push) |=> cnt == $past(cnt) - 1'b1); // R3
   AST_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (cnt == CNT_W'(DEPTH)) && $stable(head)); // R9
   AST_RW_SAME: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_eff && push) |=> $stable(cnt)); // R5
endmodule

// File: rtl/evq_top.sv
module evq_top #(
   parameter int DEPTH    = 16,
   parameter int REC_W    = 8,
   parameter int ADDR_W   = 8,
   parameter int WIN_BASE = 3,
   localparam int CNT_W   = $clog2(DEPTH + 1),
   localparam int WIN_LAST = WIN_BASE + DEPTH - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_vld,
   input  logic [REC_W-1:0]  key_rec,
   input  logic              gpi_vld,
   input  logic [REC_W-1:0]  gpi_rec,
   input  logic              gpi_rec_en,
   input  logic              lgc_vld,
   input  logic [REC_W-1:0]  lgc_rec,
   input  logic              lgc_rec_en,
   input  logic              bus_busy,
   input  logic              rd_stb,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REC_W-1:0]  rd_data,
   output logic [CNT_W-1:0]  ev_count,
   input  logic              ovf_clr,
   input  logic              ovf_irq_en,
   output logic              ovf_flag,
   output logic              irq
);
   import evq_pkg::*;

   generate
      if (WIN_LAST >= (1 << ADDR_W)) begin : g_bad_win
         $error("evq_top: read window exceeds address space");
      end
      if (WIN_BASE < 1) begin : g_bad_base
         $error("evq_top: WIN_BASE must be at least 1");
      end
   endgenerate

   logic [SRC_N-1:0] cap, hfull, grant, drop;
   logic [REC_W-1:0] src_din  [SRC_N];
   logic [REC_W-1:0] src_hold [SRC_N];
   logic [REC_W-1:0] wdata;
   logic             push, q_ovf, win_hit;
   logic [REC_W-1:0] head;

   assign cap[SRC_KEY]     = key_vld;
   assign cap[SRC_GPI]     = gpi_vld & gpi_rec_en;
   assign cap[SRC_LGC]     = lgc_vld & lgc_rec_en;
   assign src_din[SRC_KEY] = key_rec;
   assign src_din[SRC_GPI] = gpi_rec;
   assign src_din[SRC_LGC] = lgc_rec;

   generate
      for (genvar s = 0; s < SRC_N; s++) begin : g_src
         evq_hold #(.W(REC_W)) u_hold (
            .clk  (clk),
            .rst_n(rst_n),
            .cap  (cap[s]),
            .din  (src_din[s]),
            .take (grant[s]),
            .full (hfull[s]),
            .dout (src_hold[s]),
            .drop (drop[s])
         );
      end
   endgenerate

   evq_arb #(.N(SRC_N)) u_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (hfull),
      .busy (bus_busy),
      .grant(grant)
   );

   always_comb begin
      wdata = '0;
      for (int s = 0; s < SRC_N; s++) begin
         if (grant[s]) wdata = src_hold[s];
      end
   end
   assign push = |grant;

   assign win_hit = rd_stb && (rd_addr >= ADDR_W'(WIN_BASE)) && (rd_addr <= ADDR_W'(WIN_LAST));

   evq_queue #(.DEPTH(DEPTH), .W(REC_W)) u_queue (
      .clk  (clk),
      .rst_n(rst_n),
      .push (push),
      .wdata(wdata),
      .pop  (win_hit),
      .cnt  (ev_count),
      .head (head),
      .ovf  (q_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         ovf_flag <= 1'b0;
      end else begin
         rd_data <= (win_hit && ev_count != '0) ? head : '0;
         if (q_ovf || (|drop)) ovf_flag <= 1'b1;
         else if (ovf_clr)     ovf_flag <= 1'b0;
      end
   end

   assign irq = ovf_flag & ovf_irq_en;

   AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_busy |-> !push); // R6
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clr) |=> ovf_flag); // R10
   AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (win_hit && ev_count == '0 && !push) |=> (rd_data == '0) && (ev_count == '0)); // R4
   AST_OUT_WIN: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !win_hit) |=> rd_data == '0); // R3
   AST_KEY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (key_vld && !hfull[SRC_KEY]) |=> hfull[SRC_KEY]); // R8
endmodule

// File: tb/sim_evq_top.sv
`timescale 1ns/1ps
module sim_evq_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       key_vld = 0, gpi_vld = 0, lgc_vld = 0;
   logic [7:0] key_rec = 0, gpi_rec = 0, lgc_rec = 0;
   logic       gpi_rec_en = 0, lgc_rec_en = 0, bus_busy = 0;
   logic       rd_stb = 0, ovf_clr = 0, ovf_irq_en = 0;
   logic [7:0] rd_addr = 0;
   logic [7:0] rd_data;
   logic [4:0] ev_count;
   logic       ovf_flag, irq;

   always #4 clk = ~clk;

   evq_top u0 (
      .clk(clk), .rst_n(rst_n),
      .key_vld(key_vld), .key_rec(key_rec),
      .gpi_vld(gpi_vld), .gpi_rec(gpi_rec), .gpi_rec_en(gpi_rec_en),
      .lgc_vld(lgc_vld), .lgc_rec(lgc_rec), .lgc_rec_en(lgc_rec_en),
      .bus_busy(bus_busy), .rd_stb(rd_stb), .rd_addr(rd_addr),
      .rd_data(rd_data), .ev_count(ev_count),
      .ovf_clr(ovf_clr), .ovf_irq_en(ovf_irq_en),
      .ovf_flag(ovf_flag), .irq(irq)
   );

   int         n_chk = 0, n_bad = 0;
   bit         done = 0;
   logic [7:0] m_q [16];
   int         m_cnt = 0;
   bit         m_hf [3];
   logic [7:0] m_hd [3];
   bit         m_flag = 0;
   logic [7:0] m_rd = 0;

   function automatic bit in_win(logic [7:0] a);
      return a >= 8'h03 && a <= 8'h12;
   endfunction

   task automatic model_step();
      int  g = -1;
      bit  ovf = 0;
      bit  cp [3];
      logic [7:0] dn [3];
      cp[0] = key_vld; cp[1] = gpi_vld && gpi_rec_en; cp[2] = lgc_vld && lgc_rec_en;
      dn[0] = key_rec; dn[1] = gpi_rec; dn[2] = lgc_rec;
      if (!bus_busy)
         for (int i = 2; i >= 0; i--) if (m_hf[i]) g = i;
      m_rd = 8'h00;
      if (rd_stb && in_win(rd_addr) && m_cnt > 0) begin
         m_rd = m_q[0];
         for (int i = 0; i < 15; i++) m_q[i] = m_q[i+1];
         m_cnt--;
      end
      if (g >= 0) begin
         if (m_cnt < 16) begin m_q[m_cnt] = m_hd[g]; m_cnt++; end
         else ovf = 1;
         m_hf[g] = 0;
      end
      for (int i = 0; i < 3; i++)
         if (cp[i]) begin
            if (m_hf[i]) ovf = 1;
            else begin m_hf[i] = 1; m_hd[i] = dn[i]; end
         end
      if (ovf) m_flag = 1;
      else if (ovf_clr) m_flag = 0;
   endtask

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic tick(string tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk(tag, "ev_count", ev_count, m_cnt);
      chk(tag, "rd_data", rd_data, m_rd);
      chk(tag, "ovf_flag", ovf_flag, m_flag);
      chk(tag, "irq", irq, m_flag && ovf_irq_en);
   endtask

   task automatic quiet();
      key_vld = 0; gpi_vld = 0; lgc_vld = 0; rd_stb = 0; ovf_clr = 0; bus_busy = 0;
   endtask

   task automatic rd(string tag, logic [7:0] a);
      rd_stb = 1; rd_addr = a; tick(tag); rd_stb = 0;
   endtask

   task automatic key(string tag, logic [7:0] r);
      key_vld = 1; key_rec = r; tick(tag); key_vld = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 3; i++) begin m_hf[i] = 0; m_hd[i] = 0; end
      for (int i = 0; i < 16; i++) m_q[i] = 0;
      void'($urandom(32'h0E5D_1234));
      repeat (3) @(negedge clk);
      chk("R2", "reset ev_count", ev_count, 0);
      chk("R2", "reset rd_data", rd_data, 0);
      chk("R2", "reset irq", irq, 0);
      rst_n = 1;
      @(negedge clk);

      // R4: read of empty queue
      rd("R4", 8'h03);
      // R1 R2: three key records then read back in order
      key("R1", 8'h85); key("R1", 8'h05); key("R1", 8'h7F);
      tick("R2");
      rd("R3", 8'h12); rd("R1", 8'h07);
      // R3: reads outside window do not pop
      rd("R3", 8'h02); rd("R3", 8'h13);
      rd("R1", 8'h0A);
      // R6 R7: all three holds loaded while busy, drained in priority order
      gpi_rec_en = 1; lgc_rec_en = 1; bus_busy = 1;
      key_vld = 1; key_rec = 8'h11; gpi_vld = 1; gpi_rec = 8'h22; lgc_vld = 1; lgc_rec = 8'h33;
      tick("R6");
      key_vld = 0; gpi_vld = 0; lgc_vld = 0;
      tick("R6"); tick("R6");
      bus_busy = 0;
      tick("R7"); tick("R7"); tick("R7"); tick("R7");
      rd("R7", 8'h04); rd("R7", 8'h04); rd("R7", 8'h04);
      // R8: disabled sources are ignored
      gpi_rec_en = 0; lgc_rec_en = 0;
      gpi_vld = 1; lgc_vld = 1; tick("R8"); gpi_vld = 0; lgc_vld = 0;
      tick("R8"); tick("R8");
      // R9: fill to 16 then one more
      for (int i = 0; i < 17; i++) key("R9", 8'h40 + 8'(i));
      tick("R9"); tick("R9");
      ovf_irq_en = 1; tick("R11");
      // R5: full store, read and write on the same edge
      key("R5", 8'hC1);
      rd_stb = 1; rd_addr = 8'h05; tick("R5"); rd_stb = 0;
      // R10: clear, and set-wins-over-clear
      ovf_clr = 1; tick("R10"); ovf_clr = 0;
      tick("R10");
      for (int i = 0; i < 16; i++) rd("R1", 8'h03 + 8'(i));
      rd("R4", 8'h08);
      // R9: holding-register collision while busy
      bus_busy = 1; key("R9", 8'hA0); key("R9", 8'hA1);
      ovf_clr = 1; key("R10", 8'hA2); ovf_clr = 0;
      bus_busy = 0; tick("R6"); tick("R6");
      ovf_irq_en = 0; tick("R11");

      // random phase
      for (int n = 0; n < 4000; n++) begin
         key_vld    = ($urandom_range(0, 3) == 0);
         key_rec    = 8'($urandom);
         gpi_vld    = ($urandom_range(0, 3) == 0);
         gpi_rec    = 8'($urandom);
         lgc_vld    = ($urandom_range(0, 3) == 0);
         lgc_rec    = 8'($urandom);
         gpi_rec_en = ($urandom_range(0, 4) != 0);
         lgc_rec_en = ($urandom_range(0, 4) != 0);
         bus_busy   = ($urandom_range(0, 2) == 0);
         rd_stb     = ($urandom_range(0, 2) == 0);
         rd_addr    = 8'($urandom_range(0, 21));
         ovf_clr    = ($urandom_range(0, 15) == 0);
         ovf_irq_en = ($urandom_range(0, 1) == 1);
         tick("R1");
      end
      quiet();
      tick("R2");
      finish_run();
   end
endmodule